// File: doc/BRIEF.md
# UART Host Register and Interrupt Block

This block is the register-facing half of a simple UART. A 32-bit host bus reaches four word registers through it: a data register that both feeds the transmit queue and drains the receive queue, a control register holding the frame and line settings, an interrupt status register and an interrupt enable register. Small byte FIFOs sit on both sides of the block. The serial core, which is outside this block, takes transmit bytes and delivers receive bytes through plain handshake pins.

Each of the two interrupt sources captures its event in a sticky bit. Software clears a bit by writing 1 to it. The enable register masks the sources one by one. The OR of the masked sources shows up as a read-only summary bit in the control register. The summary drives the single interrupt output only while the host interrupt enable bit is set. The frame is always 8 data bits and 1 stop bit. Parity can be none, odd or even.

The host drives a word index, not a byte address: word 0 is data, word 1 is control, word 2 is interrupt status and word 3 is interrupt enable. Reads have no side effects. Every FIFO action is caused by a write.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, data reads 0x100, the control, status and enable registers read 0, and irq is 0.
- R2: A data read returns the oldest receive byte in bits 7:0 (0 when the receive FIFO is empty). Bit 8 is 1 while the transmit FIFO has room. Bit 9 is 1 while the receive FIFO holds a byte. All other bits read 0.
- R3: A data write with bit 8 set queues bits 7:0 for transmit. The core sees the bytes on tx_char in write order. A write to a full transmit FIFO is dropped.
- R4: A data write with bit 9 set removes the oldest receive byte. On an empty receive FIFO this has no effect. A byte offered on rx_put when the receive FIFO is full is dropped.
- R5: Control layout: bits 1:0 parity (0 none, 1 odd, 2 even; a write of 3 stores 0, so mark and space parity cannot be selected), bits 3:2 interface mode (0 disables the UART, 2 is the DCE mode), bit 4 transmit break, bit 5 host interrupt enable, bit 6 read-only summary. uart_on is 1 while the mode field is non-zero.
- R6: Status bit 0 (receive valid) is set in every cycle that the receive FIFO is non-empty. Status bit 1 (transmit empty) is set in the cycle that the transmit FIFO drains to empty. Both bits stay set until a 1 is written to them. When a set event and a clear fall in the same cycle, the set wins.
- R7: Enable register bits 1:0 mask the matching status bits. The summary bit is the OR of status AND enable.
- R8: irq is 1 exactly when the summary is 1 and the host interrupt enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, 0 when not reading) |
| tx_avail | output | 1 | Transmit FIFO holds a byte |
| tx_char | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Core consumes tx_char |
| rx_put | input | 1 | Core delivers rx_char |
| rx_char | input | 8 | Received byte |
| cfg_parity | output | 2 | Parity setting |
| cfg_mode | output | 2 | Interface mode field |
| uart_on | output | 1 | UART enabled (mode non-zero) |
| tx_break | output | 1 | Hold the line in break |
| irq | output | 1 | Host interrupt |

## Verification
Two collisions are provoked on purpose. In the first, a write-one-to-clear of the transmit-empty bit lands in the same cycle that the core takes the last transmit byte; the status read afterwards must still show the bit, because the set wins. In the second, one data write carries both flag bits, so one byte is popped from the receive FIFO and another is pushed to the transmit FIFO in the same cycle; the bench judges this by the new transmit head and the cleared receive flag. Transmit bytes go through a scoreboard queue and are compared as the core takes them, so a dropped byte on overflow or a reordered byte shows up as a mismatch.

// File: rtl/uart_host_regs.sv
module uart_host_regs #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_avail,
  output logic [7:0]  tx_char,
  input  logic        tx_take,
  input  logic        rx_put,
  input  logic [7:0]  rx_char,
  output logic [1:0]  cfg_parity,
  output logic [1:0]  cfg_mode,
  output logic        uart_on,
  output logic        tx_break,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [1:0]    ist_q, ien_q;
  logic          hie_q;
  logic [31:0]   rd_val;

  wire wr_data = bus_sel & bus_wr & (bus_addr == 2'd0);
  wire wr_ctrl = bus_sel & bus_wr & (bus_addr == 2'd1);
  wire wr_ist  = bus_sel & bus_wr & (bus_addr == 2'd2);
  wire wr_ien  = bus_sel & bus_wr & (bus_addr == 2'd3);

  wire tx_push = wr_data & bus_wdata[8] & (tx_cnt != FULL);
  wire tx_pop  = tx_take & (tx_cnt != '0);
  wire rx_pop  = wr_data & bus_wdata[9] & (rx_cnt != '0);
  wire rx_push = rx_put & (rx_cnt != FULL);

  wire tx_drained = tx_pop & ~tx_push & (tx_cnt == CW'(1));
  wire [1:0] ist_set = {tx_drained, rx_cnt != '0};
  wire [1:0] ist_clr = wr_ist ? bus_wdata[1:0] : 2'b00;
  wire summary = |(ist_q & ien_q);
  wire unused_hi = ^bus_wdata[31:10];

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rx_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_parity <= 2'd0;
      cfg_mode   <= 2'd0;
      tx_break   <= 1'b0;
      hie_q      <= 1'b0;
      ist_q      <= 2'b00;
      ien_q      <= 2'b00;
    end else begin
      if (wr_ctrl) begin
        cfg_parity <= (bus_wdata[1:0] == 2'd3) ? 2'd0 : bus_wdata[1:0];
        cfg_mode   <= bus_wdata[3:2];
        tx_break   <= bus_wdata[4];
        hie_q      <= bus_wdata[5];
      end
      if (wr_ien) ien_q <= bus_wdata[1:0];
      ist_q <= ist_set | (ist_q & ~ist_clr);
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    rd_val = {22'd0, rx_cnt != '0, tx_cnt != FULL,
                         (rx_cnt != '0) ? rx_mem[rx_rp] : 8'h00};
      2'd1:    rd_val = {25'd0, summary, hie_q, tx_break, cfg_mode, cfg_parity};
      2'd2:    rd_val = {30'd0, ist_q};
      default: rd_val = {30'd0, ien_q};
    endcase
  end

  assign bus_rdata = (bus_sel & ~bus_wr) ? rd_val : 32'd0;
  assign tx_avail  = tx_cnt != '0;
  assign tx_char   = tx_mem[tx_rp];
  assign uart_on   = cfg_mode != 2'd0;
  assign irq       = summary & hie_q;
endmodule

module uart_host_regs_chk #(
  parameter int DEPTH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        tx_take,
  input logic        rx_put,
  input logic [$clog2(DEPTH):0] tx_cnt,
  input logic [$clog2(DEPTH):0] rx_cnt,
  input logic [1:0]  ist_q,
  input logic [1:0]  ien_q,
  input logic        hie_q,
  input logic        irq
);
  wire data_wr = bus_sel && bus_wr && bus_addr == 2'd0;
  wire push_req = data_wr && bus_wdata[8];
  wire pop_req  = data_wr && bus_wdata[9];
  wire clr_tx   = bus_sel && bus_wr && bus_addr == 2'd2 && bus_wdata[1];

  p_tx_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == DEPTH && push_req && !tx_take) |=> tx_cnt == DEPTH);

  p_rx_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == 0 && pop_req && !rx_put) |=> rx_cnt == 0);

  p_rx_valid_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt != 0) |=> ist_q[0]);

  p_tx_empty_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == 1 && tx_take && !push_req) |=> ist_q[1]);

  p_tx_empty_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ist_q[1] && !clr_tx) |=> ist_q[1]);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (hie_q && (ist_q & ien_q) != 2'b00));
endmodule

bind uart_host_regs uart_host_regs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_take(tx_take),
  .rx_put(rx_put), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ist_q(ist_q),
  .ien_q(ien_q), .hie_q(hie_q), .irq(irq)
);

// File: tb/sim_uart_host_regs.sv
module sim_uart_host_regs;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic tx_avail, tx_take, rx_put = 0, uart_on, tx_break, irq;
  logic [7:0] tx_char, rx_char = 0;
  logic [1:0] cfg_parity, cfg_mode;
  logic mon_take = 0, man_take = 0, drain_en = 0;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  logic [31:0] rv;

  assign tx_take = mon_take | man_take;

  always #10 clk = ~clk;

  uart_host_regs #(.DEPTH(DEPTH)) u0 (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .tx_avail, .tx_char, .tx_take, .rx_put, .rx_char, .cfg_parity,
    .cfg_mode, .uart_on, .tx_break, .irq
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic send(input logic [7:0] c, input bit accepted);
    if (accepted) exp_q.push_back(c);
    wr(2'd0, 32'h100 | c);
  endtask

  task automatic deliver(input logic [7:0] c);
    @(negedge clk);
    rx_put = 1; rx_char = c;
    @(negedge clk);
    rx_put = 0;
  endtask

  always @(negedge clk) begin
    mon_take = 0;
    if (drain_en && tx_avail) begin
      if (exp_q.size() == 0) chk("R3 unexpected byte", tx_char, 32'hx);
      else chk("R3 tx order", tx_char, exp_q.pop_front());
      mon_take = 1;
    end
  end

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2'd0, rv); chk("R1 data reset", rv, 32'h100);
    rd(2'd1, rv); chk("R1 ctrl reset", rv, 0);
    rd(2'd2, rv); chk("R1 ist reset", rv, 0);
    rd(2'd3, rv); chk("R1 ien reset", rv, 0);
    chk("R1 irq reset", irq, 0);

    wr(2'd1, 32'h3B);
    rd(2'd1, rv); chk("R5 parity 3 stores 0", rv, 32'h38);
    wr(2'd1, 32'h30);
    chk("R5 mode 0 disables", uart_on, 0);
    wr(2'd1, 32'h7A);
    rd(2'd1, rv); chk("R5 ctrl readback, summary RO", rv, 32'h3A);
    chk("R5 outputs", {cfg_parity, cfg_mode, uart_on, tx_break}, {2'd2, 2'd2, 1'b1, 1'b1});

    for (int i = 0; i < DEPTH; i++) send(8'hC0 + 8'(i), 1);
    rd(2'd0, rv); chk("R2 tx flag 0 when full", rv, 32'h000);
    send(8'hEE, 0);
    drain_en = 1;
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    drain_en = 0;
    rd(2'd2, rv); chk("R6 tx empty set", rv, 32'h2);
    chk("R7 masked by enable", irq, 0);
    wr(2'd3, 32'h2);
    chk("R8 irq enabled", irq, 1);
    rd(2'd1, rv); chk("R7 summary bit", rv, 32'h7A);
    wr(2'd1, 32'h1A);
    chk("R8 irq gated by host enable", irq, 0);
    rd(2'd1, rv); chk("R7 summary without host enable", rv, 32'h5A);
    wr(2'd1, 32'h3A);
    wr(2'd2, 32'h2);
    rd(2'd2, rv); chk("R6 w1c", rv, 0);
    chk("R8 irq after clear", irq, 0);

    deliver(8'hA5); deliver(8'h3C);
    rd(2'd0, rv); chk("R2 rx head", rv, 32'h3A5);
    rd(2'd2, rv); chk("R6 rx valid", rv, 32'h1);
    chk("R7 rx masked", irq, 0);
    wr(2'd2, 32'h1);
    rd(2'd2, rv); chk("R6 rx valid holds while nonempty", rv, 32'h1);
    wr(2'd0, 32'h200);
    rd(2'd0, rv); chk("R4 pop next", rv, 32'h33C);
    wr(2'd0, 32'h200);
    wr(2'd0, 32'h200);
    rd(2'd0, rv); chk("R4 empty", rv, 32'h100);
    deliver(8'h77);
    rd(2'd0, rv); chk("R4 pop on empty no effect", rv, 32'h377);
    wr(2'd0, 32'h200);
    wr(2'd2, 32'h1);
    rd(2'd2, rv); chk("R6 rx clear after empty", rv, 0);

    for (int i = 0; i <= DEPTH; i++) deliver(8'h10 + 8'(i));
    for (int i = 0; i < DEPTH; i++) begin
      rd(2'd0, rv); chk("R4 rx order", rv, 32'h300 | (32'h10 + i));
      wr(2'd0, 32'h200);
    end
    rd(2'd0, rv); chk("R4 overflow dropped", rv, 32'h100);
    wr(2'd2, 32'h3);

    wr(2'd0, 32'h15A);
    chk("R3 head", tx_char, 32'h5A);
    @(negedge clk);
    man_take = 1; bus_sel = 1; bus_wr = 1; bus_addr = 2'd2; bus_wdata = 32'h2;
    @(negedge clk);
    man_take = 0; bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    rd(2'd2, rv); chk("R6 set beats clear", rv, 32'h2);
    chk("R8 irq on collision", irq, 1);

    deliver(8'h81);
    wr(2'd0, 32'h366);
    rd(2'd0, rv); chk("R4 combined pop", rv, 32'h100);
    chk("R3 combined push", {tx_avail, tx_char}, {1'b1, 8'h66});
    exp_q.push_back(8'h66);
    drain_en = 1;
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    drain_en = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule